// File: doc/BRIEF.md
# Atomic Bit Command Register

A 32-bit control/status register whose bits are changed by single-bit commands. Each command names a bit by index and carries an opcode. The opcode selects one of four actions: test the bit, set it, clear it, or invert it. The test-and-modify opcodes do both: they report the bit's earlier value and change the bit at the same clock edge. No other write can land between the read and the write.

A separate word port loads the whole register at once. The three lowest bits have fixed roles. Bit 0 flags data ready and bit 1 flags an error; hardware raises both of these through set pulses. Bit 2 enables the transmitter. When a command and a word write arrive in the same cycle, the command is applied and the block reports the collision.

Top module: `bit_cmd_reg`

## Requirements
- R1: After reset the register holds all zeros, and rsp_valid, zero_flag, old_bit and collide are all 0.
- R2: A set command ORs the register with a one-hot mask at cmd_idx. A clear command ANDs the register with the mask's complement. A toggle command XORs the register with the mask. The new value shows on reg_q one cycle after the command, and no other bit changes.
- R3: A test command leaves the register unchanged. One cycle later rsp_valid is 1, old_bit holds the addressed bit's prior value, and zero_flag is 1 exactly when that bit was 0.
- R4: Test-and-set, test-and-clear and test-and-toggle report the bit's value from before the command through old_bit and zero_flag. They apply their change at the same edge, so reg_q and the response appear together one cycle later.
- R5: The cmd_op encodings are 0 test, 1 set, 2 clear, 3 toggle, 4 test-and-set, 5 test-and-clear, 6 test-and-toggle and 7 reserved.
- R6: When wr_en is high and cmd_valid is low, reg_q takes wr_data one cycle later.
- R7: When cmd_valid and wr_en are high in the same cycle, the command is applied and wr_data is dropped. collide is 1 in the following cycle and 0 otherwise.
- R8: hw_rdy_set sets bit 0 and hw_err_set sets bit 1. A hardware set wins over a clear, a toggle or a word write that hits the same bit in the same cycle.
- R9: data_ready mirrors bit 0, error_flag mirrors bit 1, and tx_enable mirrors bit 2 of the register.
- R10: Opcode 7 changes no bit and produces no response.
- R11: The plain set, clear and toggle commands (opcodes 1 to 3) produce no response. rsp_valid is high only in the cycle after a test-type command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Qualifies a bit command |
| cmd_op | input | 3 | Command opcode |
| cmd_idx | input | 5 | Addressed bit index |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 32 | Full-word write value |
| hw_rdy_set | input | 1 | Hardware pulse setting bit 0 |
| hw_err_set | input | 1 | Hardware pulse setting bit 1 |
| reg_q | output | 32 | Register contents |
| rsp_valid | output | 1 | Test response present |
| old_bit | output | 1 | Prior value of the tested bit |
| zero_flag | output | 1 | Tested bit was 0 |
| collide | output | 1 | Command and word write met last cycle |
| data_ready | output | 1 | Bit 0 status |
| error_flag | output | 1 | Bit 1 status |
| tx_enable | output | 1 | Bit 2 control |

## Verification
The bench uses several indices: the lowest bit, the highest bit, a middle bit and the three role bits. This shows whether the one-hot mask lands on the right bit and leaves its neighbours alone. Each test-and-modify opcode is issued twice in a row on the same bit. The first and second responses must then differ, which separates reporting the old value from reporting the new one.

Collision cases pair a command with an all-ones word, so a write that was wrongly accepted shows up at once. Hardware set pulses are paired with a clear or a zero word write aimed at the same bit, which checks that the set takes priority. The reserved opcode and the plain modify opcodes are checked for both register stability and the absence of any response.

// File: rtl/bit_cmd_reg.sv
module bit_cmd_reg #(
  parameter int WIDTH = 32,
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [IDXW-1:0]  cmd_idx,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             hw_rdy_set,
  input  logic             hw_err_set,
  output logic [WIDTH-1:0] reg_q,
  output logic             rsp_valid,
  output logic             old_bit,
  output logic             zero_flag,
  output logic             collide,
  output logic             data_ready,
  output logic             error_flag,
  output logic             tx_enable
);
  localparam logic [2:0] OP_TEST = 3'd0, OP_SET = 3'd1, OP_CLR = 3'd2, OP_TGL = 3'd3,
                         OP_TSET = 3'd4, OP_TCLR = 3'd5, OP_TTGL = 3'd6;

  logic [WIDTH-1:0] mask, nxt;
  logic             cur_bit, is_test;

  assign mask    = {{(WIDTH-1){1'b0}}, 1'b1} << cmd_idx;
  assign cur_bit = reg_q[cmd_idx];
  assign is_test = cmd_valid && (cmd_op == OP_TEST || cmd_op == OP_TSET ||
                                 cmd_op == OP_TCLR || cmd_op == OP_TTGL);

  always_comb begin
    nxt = reg_q;
    if (cmd_valid) begin
      case (cmd_op)
        OP_SET, OP_TSET: nxt = reg_q | mask;
        OP_CLR, OP_TCLR: nxt = reg_q & ~mask;
        OP_TGL, OP_TTGL: nxt = reg_q ^ mask;
        default:         nxt = reg_q;
      endcase
    end else if (wr_en) begin
      nxt = wr_data;
    end
    nxt[0] = nxt[0] | hw_rdy_set;
    nxt[1] = nxt[1] | hw_err_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q     <= '0;
      rsp_valid <= 1'b0;
      old_bit   <= 1'b0;
      zero_flag <= 1'b0;
      collide   <= 1'b0;
    end else begin
      reg_q     <= nxt;
      rsp_valid <= is_test;
      collide   <= cmd_valid && wr_en;
      if (is_test) begin
        old_bit   <= cur_bit;
        zero_flag <= ~cur_bit;
      end
    end
  end

  assign data_ready = reg_q[0];
  assign error_flag = reg_q[1];
  assign tx_enable  = reg_q[2];

  a_r3_test_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_TEST && !hw_rdy_set && !hw_err_set |=> reg_q == $past(reg_q));

  a_r2_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_SET || cmd_op == OP_TSET) |=> reg_q[$past(cmd_idx)]);

  a_r2_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_CLR || cmd_op == OP_TCLR) && !hw_rdy_set && !hw_err_set
    |=> !reg_q[$past(cmd_idx)]);

  a_r4_zero_reports_old: assert property (@(posedge clk) disable iff (!rst_n)
    is_test && !reg_q[cmd_idx] |=> rsp_valid && zero_flag && !old_bit);

  a_r7_collide: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && wr_en |=> collide);

  a_r8_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rdy_set |=> data_ready);

  a_r10_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd7 && !hw_rdy_set && !hw_err_set
    |=> !rsp_valid && reg_q == $past(reg_q));
endmodule

// File: tb/tb_bit_cmd_reg.sv
module tb_bit_cmd_reg;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [4:0]  cmd_idx = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        hw_rdy_set = 1'b0, hw_err_set = 1'b0;
  logic [31:0] reg_q;
  logic        rsp_valid, old_bit, zero_flag, collide, data_ready, error_flag, tx_enable;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] model = '0;
  logic exp_q[$];

  bit_cmd_reg dut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done && rsp_valid) begin
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R11 actual=unexpected response expected=none");
    end else begin
      logic e;
      e = exp_q.pop_front();
      check("R3/R4 old_bit", {31'b0, old_bit}, {31'b0, e});
      check("R3/R4 zero_flag", {31'b0, zero_flag}, {31'b0, ~e});
    end
  end

  task automatic step(input bit cv, input logic [2:0] op, input logic [4:0] idx,
                      input bit we, input logic [31:0] wd, input bit hr, input bit he,
                      input string req);
    logic [31:0] m;
    m = model;
    cmd_valid = cv; cmd_op = op; cmd_idx = idx; wr_en = we; wr_data = wd;
    hw_rdy_set = hr; hw_err_set = he;
    if (cv) begin
      if (op == 0 || op == 4 || op == 5 || op == 6) exp_q.push_back(model[idx]);
      if (op == 1 || op == 4) m[idx] = 1'b1;
      else if (op == 2 || op == 5) m[idx] = 1'b0;
      else if (op == 3 || op == 6) m[idx] = ~model[idx];
    end else if (we) m = wd;
    if (hr) m[0] = 1'b1;
    if (he) m[1] = 1'b1;
    model = m;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; wr_en = 0; hw_rdy_set = 0; hw_err_set = 0;
    check({req, " reg_q"}, reg_q, model);
    check("R7 collide", {31'b0, collide}, {31'b0, cv && we});
    check("R9 status bits", {29'b0, tx_enable, error_flag, data_ready}, {29'b0, model[2:0]});
  endtask

  initial begin
    #(PERIOD*100000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reg_q", reg_q, 32'h0);
    check("R1 flags", {28'b0, rsp_valid, zero_flag, old_bit, collide}, 32'h0);
    rst_n = 1;
    step(1, 3'd1, 5'd2,  0, 0, 0, 0, "R2 set tx");
    step(1, 3'd1, 5'd31, 0, 0, 0, 0, "R2 set msb");
    step(1, 3'd3, 5'd5,  0, 0, 0, 0, "R2 toggle");
    step(1, 3'd3, 5'd5,  0, 0, 0, 0, "R2 toggle back");
    step(1, 3'd3, 5'd17, 0, 0, 0, 0, "R2 toggle mid");
    step(1, 3'd2, 5'd2,  0, 0, 0, 0, "R2 clear");
    step(1, 3'd0, 5'd31, 0, 0, 0, 0, "R3 test set bit");
    step(1, 3'd0, 5'd7,  0, 0, 0, 0, "R3 test clear bit");
    step(1, 3'd4, 5'd9,  0, 0, 0, 0, "R4 tset first");
    step(1, 3'd4, 5'd9,  0, 0, 0, 0, "R4 tset second");
    step(1, 3'd5, 5'd9,  0, 0, 0, 0, "R4 tclr first");
    step(1, 3'd5, 5'd9,  0, 0, 0, 0, "R4 tclr second");
    step(1, 3'd6, 5'd0,  0, 0, 0, 0, "R4 ttgl first");
    step(1, 3'd6, 5'd0,  0, 0, 0, 0, "R4 ttgl second");
    step(0, 3'd0, 5'd0,  1, 32'hA5A5_0F0F, 0, 0, "R6 word write");
    step(0, 3'd0, 5'd0,  1, 32'h0000_0002, 0, 0, "R6 word write small");
    step(1, 3'd1, 5'd20, 1, 32'hFFFF_FFFF, 0, 0, "R7 collision set");
    step(1, 3'd0, 5'd20, 1, 32'hFFFF_FFFF, 0, 0, "R7 collision test");
    step(1, 3'd2, 5'd0,  0, 0, 1, 0, "R8 hw set beats clear");
    step(1, 3'd3, 5'd1,  0, 0, 0, 1, "R8 hw set beats toggle");
    step(0, 3'd0, 5'd0,  1, 32'h0, 0, 1, "R8 hw set beats word write");
    step(1, 3'd7, 5'd1,  0, 0, 0, 0, "R10 reserved opcode");
    step(1, 3'd7, 5'd3,  0, 0, 0, 0, "R10 reserved opcode again");
    step(0, 3'd0, 5'd0,  0, 0, 0, 0, "R11 idle");
    check("R11 no response", {31'b0, rsp_valid}, 32'h0);
    check("R5 queue drained", exp_q.size(), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule